// File: doc/BRIEF.md
# Index-Addressed Scratchpad with Valid Bitmap

This block is a small on-chip scratchpad that holds a dense vector and is addressed directly by an element index, for example by the column indices of a sparse matrix row. Every entry is one 32-bit word. A valid bitmap beside the data array records which entries hold a written value. A lookup of an entry whose bit is clear yields zero, so the vector never has to be zero-filled. Invalidation is done by clearing bits only. In one command it covers either the whole bitmap or one aligned segment of it, and the data cells are left as they are.

Requests arrive one at a time on a single port with a valid/ready pair. The port carries an opcode, an index, a data word and a whole-array flag. A write stores the word and marks the entry valid. A read returns the masked word one cycle later with a strobe. An accumulate adds the operand to the current contents of the entry in place, treating an invalid entry as zero. A clear drops valid bits. The controller is a two-state machine. In ST_IDLE it accepts requests. The transition ST_IDLE to ST_ACC is taken when an accumulate is accepted. ST_ACC performs the write-back and always returns to ST_IDLE in the next cycle, and the port is not ready while in ST_ACC.

Top module: `spm_scratch_top`

## Requirements
- R1: The opcode on `req_op` is 2'b00 write, 2'b01 read, 2'b10 accumulate and 2'b11 clear. An accepted write of an in-range index stores the full 32-bit word at that entry and marks it valid, so a later read of that index returns the word.
- R2: An accepted read raises `rd_valid` in the cycle after it is accepted, for exactly one cycle, with the result on `rd_data`. `rd_valid` stays low after writes, accumulates and clears.
- R3: A read of an in-range entry whose valid bit is clear returns zero.
- R4: An accumulate to an in-range index writes back (old value, or zero if the entry is invalid) plus the operand, modulo 2^32, and marks the entry valid.
- R5: After an accumulate is accepted, `req_ready` is low for exactly one cycle and then high again.
- R6: A clear with `req_all`=1 invalidates every entry in one cycle, so every read returns zero until the entry is written again.
- R7: A clear with `req_all`=0 treats `req_idx` as a segment number s. It invalidates entries s*SEG to s*SEG+SEG-1 and leaves all other entries unchanged. A segment number of DEPTH/SEG or more has no effect.
- R8: An index of DEPTH or more is ignored by writes and accumulates, and it leaves every entry unchanged. A read of such an index returns zero.
- R9: After reset every entry is invalid, `req_ready` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_op | input | 2 | Opcode: 00 write, 01 read, 10 accumulate, 11 clear |
| req_idx | input | IDX_W | Element index, or segment number for a segment clear |
| req_data | input | 32 | Write data or accumulate operand |
| req_all | input | 1 | For a clear: 1 selects the whole bitmap, 0 a single segment |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result, zero for an invalid or out-of-range entry |

## Verification
The bench builds the block with DEPTH=64, SEG=16 and IDX_W=7. With these values half of the index space lies beyond the array, so out-of-range writes that would alias onto low entries after truncation can be reached. The four segments are small enough that random segment clears hit populated regions often, and segment numbers 4 to 127 exercise the no-effect case. The small depth also means random writes and accumulates revisit the same entries many times, so accumulation on both valid and freshly cleared entries is covered.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_ACC   = 2'b10,
        OP_CLEAR = 2'b11
    } spm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACC  = 1'b1
    } spm_state_e;

endpackage

// File: rtl/spm_bitmap.sv
module spm_bitmap #(
    parameter int DEPTH = 256,
    parameter int SEG   = 32,
    parameter int IDX_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [$clog2(DEPTH)-1:0] set_idx,
    input  logic                     clr_en,
    input  logic                     clr_all,
    input  logic [IDX_W-1:0]         clr_seg,
    input  logic                     look_en,
    input  logic [IDX_W-1:0]         look_idx,
    output logic                     hit_q
);
    localparam int AW   = $clog2(DEPTH);
    localparam int NSEG = DEPTH / SEG;
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

    logic [DEPTH-1:0] bits;
    logic [DEPTH-1:0] seg_mask;
    logic             look_inr;

    // one comparator per segment; a segment number past the end matches none
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_mask[g*SEG +: SEG] = {SEG{clr_seg == IDX_W'(g)}};
    end

    assign look_inr = ({1'b0, look_idx} < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            if (clr_en) begin
                bits <= clr_all ? '0 : (bits & ~seg_mask);
            end
            if (set_en) begin
                bits[set_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (look_en) begin
            hit_q <= look_inr && bits[look_idx[AW-1:0]];
        end
    end

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_all) |=> (bits == '0));

    assert_seg_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !clr_all) |=> ((bits & ~$past(seg_mask)) == ($past(bits) & ~$past(seg_mask))));

    assert_set_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits[$past(set_idx)]);

endmodule

// File: rtl/spm_array.sv
module spm_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DW-1:0]            rd_q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
    import spm_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 9,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [IDX_W-1:0]         req_idx,
    input  logic [DW-1:0]            req_data,
    input  logic                     req_all,
    input  logic [DW-1:0]            arr_q,
    input  logic                     hit_q,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [DW-1:0]            wr_data,
    output logic                     look_en,
    output logic                     clr_en,
    output logic                     clr_all,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

    spm_state_e    state, state_nx;
    spm_op_e       op;
    logic          accept;
    logic          idx_inr;
    logic [AW-1:0] acc_idx_q;
    logic          acc_inr_q;
    logic [DW-1:0] acc_opnd_q;
    logic          rdv_q;
    logic [DW-1:0] masked;

    assign op      = spm_op_e'(req_op);
    assign idx_inr = ({1'b0, req_idx} < LIMIT);
    assign masked  = hit_q ? arr_q : '0;
    assign accept  = req_valid && req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && op == OP_ACC) state_nx = ST_ACC;
            ST_ACC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        req_ready = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = req_idx[AW-1:0];
        wr_data   = req_data;
        look_en   = 1'b0;
        clr_en    = 1'b0;
        clr_all   = req_all;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                wr_en     = req_valid && op == OP_WRITE && idx_inr;
                look_en   = req_valid && (op == OP_READ || op == OP_ACC);
                clr_en    = req_valid && op == OP_CLEAR;
            end
            ST_ACC: begin
                wr_en   = acc_inr_q;
                wr_addr = acc_idx_q;
                wr_data = masked + acc_opnd_q;
            end
            default: ;
        endcase
    end

    // operand capture and read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_idx_q  <= '0;
            acc_inr_q  <= 1'b0;
            acc_opnd_q <= '0;
            rdv_q      <= 1'b0;
        end else begin
            rdv_q <= accept && op == OP_READ;
            if (accept && op == OP_ACC) begin
                acc_idx_q  <= req_idx[AW-1:0];
                acc_inr_q  <= idx_inr;
                acc_opnd_q <= req_data;
            end
        end
    end

    assign rd_valid = rdv_q;
    assign rd_data  = rdv_q ? masked : '0;

    assert_acc_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC) |=> (state == ST_IDLE));

    assert_acc_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ACC) |=> !req_ready);

    assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op != OP_READ) |=> !rd_valid);

endmodule

// File: rtl/spm_scratch_top.sv
module spm_scratch_top #(
    parameter int DEPTH = 256,
    parameter int SEG   = 32,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [31:0]      req_data,
    input  logic             req_all,
    output logic             rd_valid,
    output logic [31:0]      rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = 32;

    logic          wr_en, look_en, clr_en, clr_all, hit_q;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data, arr_q;

    spm_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_idx(req_idx), .req_data(req_data), .req_all(req_all),
        .arr_q(arr_q), .hit_q(hit_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .look_en(look_en), .clr_en(clr_en), .clr_all(clr_all),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    spm_bitmap #(.DEPTH(DEPTH), .SEG(SEG), .IDX_W(IDX_W)) u_bitmap (
        .clk(clk), .rst_n(rst_n),
        .set_en(wr_en), .set_idx(wr_addr),
        .clr_en(clr_en), .clr_all(clr_all), .clr_seg(req_idx),
        .look_en(look_en), .look_idx(req_idx),
        .hit_q(hit_q)
    );

    spm_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(look_en), .rd_addr(req_idx[AW-1:0]),
        .rd_q(arr_q)
    );

    assert_zero_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !hit_q) |-> (rd_data == '0));

    assert_idle_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(req_valid)) |-> 1'b0);

endmodule

// File: tb/spm_scratch_top_bench.sv
module spm_scratch_top_bench;
    localparam int DEPTH = 64;
    localparam int SEG   = 16;
    localparam int IDX_W = 7;
    localparam int NSEG  = DEPTH / SEG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = 2'b00;
    logic [IDX_W-1:0] req_idx = '0;
    logic [31:0]      req_data = '0;
    logic             req_all = 1'b0;
    logic             rd_valid;
    logic [31:0]      rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_data [DEPTH];
    bit          m_vld  [DEPTH];

    always #5 clk = ~clk;

    spm_scratch_top #(.DEPTH(DEPTH), .SEG(SEG), .IDX_W(IDX_W)) u_spm_scratch_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_idx(req_idx), .req_data(req_data), .req_all(req_all),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] exp_read(int idx);
        if (idx >= DEPTH) return 32'd0;
        return m_vld[idx] ? m_data[idx] : 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] op, int idx, logic [31:0] d, logic all);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_idx   = IDX_W'(idx);
        req_data  = d;
        req_all   = all;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(int idx, logic [31:0] d);
        issue(2'b00, idx, d, 1'b0);
        check("R2 no strobe after write", {31'd0, rd_valid}, 32'd0);
        if (idx < DEPTH) begin m_data[idx] = d; m_vld[idx] = 1'b1; end
    endtask

    task automatic do_read(int idx, string req);
        issue(2'b01, idx, 32'd0, 1'b0);
        check("R2 read strobe", {31'd0, rd_valid}, 32'd1);
        check(req, rd_data, exp_read(idx));
        @(negedge clk);
        check("R2 strobe one cycle", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic do_acc(int idx, logic [31:0] d);
        issue(2'b10, idx, d, 1'b0);
        check("R5 busy after accumulate", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        check("R5 ready again", {31'd0, req_ready}, 32'd1);
        if (idx < DEPTH) begin m_data[idx] = exp_read(idx) + d; m_vld[idx] = 1'b1; end
    endtask

    task automatic do_clear(int seg, logic all);
        issue(2'b11, seg, 32'd0, all);
        if (all) begin
            for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        end else if (seg < NSEG) begin
            for (int i = seg*SEG; i < seg*SEG + SEG; i++) m_vld[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = 32'd0; m_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R9 no strobe after reset", {31'd0, rd_valid}, 32'd0);
        do_read(5, "R9 entry invalid after reset");
        do_read(DEPTH-1, "R3 unwritten reads zero");

        // R1 write then read
        do_write(3, 32'hDEAD_BEEF);
        do_read(3, "R1 written value returned");
        do_write(DEPTH-1, 32'h1234_5678);
        do_read(DEPTH-1, "R1 last entry");

        // R4 accumulate on invalid and wrap
        do_acc(10, 32'd77);
        do_read(10, "R4 accumulate into invalid entry");
        do_write(11, 32'hFFFF_FFFF);
        do_acc(11, 32'd2);
        do_read(11, "R4 accumulate wraps modulo 2^32");
        do_acc(11, 32'd5);
        do_read(11, "R4 accumulate onto valid entry");

        // R8 out-of-range
        do_write(0, 32'hAAAA_0000);
        do_write(DEPTH, 32'h5555_5555);
        do_read(0, "R8 out-of-range write leaves entry 0");
        do_acc(DEPTH, 32'd9);
        do_read(0, "R8 out-of-range accumulate leaves entry 0");
        do_read(DEPTH, "R8 out-of-range read is zero");

        // R7 segment clear with boundaries
        for (int i = 0; i < DEPTH; i++) do_write(i, 32'h100 + 32'(i));
        do_clear(1, 1'b0);
        do_read(SEG-1, "R7 entry below segment kept");
        do_read(SEG, "R7 first entry of segment cleared");
        do_read(2*SEG-1, "R7 last entry of segment cleared");
        do_read(2*SEG, "R7 entry above segment kept");
        do_clear(NSEG, 1'b0);
        do_read(0, "R7 out-of-range segment no effect");
        do_read(DEPTH-1, "R7 out-of-range segment no effect high");
        do_acc(SEG, 32'd4);
        do_read(SEG, "R4 accumulate after clear starts from zero");

        // R6 clear all
        do_clear(0, 1'b1);
        do_read(0, "R6 cleared entry reads zero");
        do_read(DEPTH-1, "R6 cleared last entry reads zero");
        do_write(7, 32'hCAFE_F00D);
        do_read(7, "R6 write after clear valid");

        // constrained random mix
        for (int n = 0; n < 1500; n++) begin
            int r, idx;
            r   = int'($urandom % 100);
            idx = (($urandom % 10) == 0) ? int'(DEPTH + ($urandom % DEPTH))
                                         : int'($urandom % DEPTH);
            if (r < 30)      do_write(idx, $urandom);
            else if (r < 65) do_read(idx, "R1 random read");
            else if (r < 90) do_acc(idx, $urandom % 1000);
            else if (r < 98) do_clear(int'($urandom % (NSEG + 2)), 1'b0);
            else             do_clear(0, 1'b1);
        end
        for (int i = 0; i < DEPTH; i++) do_read(i, "R7 final sweep");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule